// File: doc/BRIEF.md
# Ternary Prefix Match Memory

This block holds a small table of ternary patterns and answers a longest-prefix query on a 32-bit key. Each slot stores a value, a care mask (a mask bit of 0 means the key bit is ignored) and an 8-bit result code. The block compares a key against every slot at once and returns a hit flag, the slot index and the result code of the winner. When more than one slot matches, the lowest-numbered slot wins.

Software keeps the slots sorted so that longer prefixes sit at lower indices. Under that ordering, the lowest-index hit is also the most specific route. Slots are written or cleared one per cycle through a simple write port. A query issued in a cycle returns a registered answer on the following cycle.

Top module: `tpm_top`

## Requirements
- R1: After reset every slot is invalid, and out_valid, out_hit, out_index and out_result are all 0.
- R2: A slot matches a key when it is valid and ((key XOR value) AND mask) is zero in all 32 bits. A mask bit of 0 makes that key bit don't-care.
- R3: When several slots match, the reported index is the lowest matching index, and out_result is that slot's stored result.
- R4: A query presented with q_valid=1 at a clock edge produces out_valid=1 after that same edge. out_hit, out_index and out_result are held until the next query, and out_valid is 0 after an edge at which q_valid=0.
- R5: When no slot matches, out_hit=0, out_index=0 and out_result=0.
- R6: A write with wr_en=1 stores wr_value, wr_mask, wr_result and the valid flag wr_keep into slot wr_index at that edge. wr_keep=0 invalidates the slot.
- R7: A query at the same edge as a write sees the table contents from before the write. The written data affects only later queries.
- R8: A slot whose mask is all zero (a /0 default route) matches every key. At the highest index it is chosen only when no other slot matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_index | input | 4 | Slot to write |
| wr_value | input | 32 | Pattern value |
| wr_mask | input | 32 | Care mask, 1 = compare |
| wr_result | input | 8 | Result code |
| wr_keep | input | 1 | Valid flag to store, 0 invalidates |
| q_valid | input | 1 | Query strobe |
| q_key | input | 32 | Query key |
| out_valid | output | 1 | Answer valid, one cycle after query |
| out_hit | output | 1 | Some slot matched |
| out_index | output | 4 | Winning slot |
| out_result | output | 8 | Winning result code |

## Verification
A table write and a query can land on the same clock edge, and the query must then see the table as it was before the write. The bench provokes this by driving a query together with a write to the slot that would otherwise win, and also together with an invalidation of the current winner. It checks that the answer reflects the old table, and that a follow-up query reflects the new one. All other answers are compared against a longest-prefix model inside the bench that scans the bench's own copy of the table.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int KEY_W = 32;
    localparam int RES_W = 8;

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] value;
        logic [KEY_W-1:0] mask;
        logic [RES_W-1:0] result;
    } slot_t;

    function automatic logic slot_hits(input slot_t s, input logic [KEY_W-1:0] key);
        return s.valid && (((key ^ s.value) & s.mask) == '0);
    endfunction
endpackage

// File: rtl/tpm_store.sv
module tpm_store
    import tpm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  slot_t            wr_slot,
    output slot_t            slots [DEPTH]
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[i] <= '0;
            else if (wr_en && wr_index == IDX_W'(i))
                slots[i] <= wr_slot;
        end
    end
endmodule

// File: rtl/tpm_compare.sv
module tpm_compare
    import tpm_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  slot_t            slots [DEPTH],
    input  logic [KEY_W-1:0] key,
    output logic [DEPTH-1:0] hits
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hits[i] = slot_hits(slots[i], key);
    end
endmodule

// File: rtl/tpm_prio.sv
module tpm_prio #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hits,
    output logic             any,
    output logic [IDX_W-1:0] index
);
    always_comb begin
        any   = 1'b0;
        index = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any   = 1'b1;
                index = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (any) assert_lowest_R3: assert (hits[index] && ((hits & ((DEPTH'(1) << index) - DEPTH'(1))) == '0));
    end
endmodule

// File: rtl/tpm_top.sv
module tpm_top
    import tpm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [RES_W-1:0] wr_result,
    input  logic             wr_keep,
    input  logic             q_valid,
    input  logic [KEY_W-1:0] q_key,
    output logic             out_valid,
    output logic             out_hit,
    output logic [IDX_W-1:0] out_index,
    output logic [RES_W-1:0] out_result
);
    slot_t            slots [DEPTH];
    slot_t            wr_slot;
    logic [DEPTH-1:0] hits;
    logic             any;
    logic [IDX_W-1:0] win;

    assign wr_slot = '{valid: wr_keep, value: wr_value, mask: wr_mask, result: wr_result};

    tpm_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index),
        .wr_slot(wr_slot), .slots(slots)
    );

    tpm_compare #(.DEPTH(DEPTH)) u_cmp (.slots(slots), .key(q_key), .hits(hits));

    tpm_prio #(.DEPTH(DEPTH)) u_prio (.hits(hits), .any(any), .index(win));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_hit    <= 1'b0;
            out_index  <= '0;
            out_result <= '0;
        end else begin
            out_valid <= q_valid;
            if (q_valid) begin
                out_hit    <= any;
                out_index  <= any ? win : '0;
                out_result <= any ? slots[win].result : '0;
            end
        end
    end

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(q_valid));
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(q_valid) |-> ($stable(out_hit) && $stable(out_index) && $stable(out_result)));
    assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !out_hit |-> (out_index == '0 && out_result == '0));
    assert_prior_table_R7: assert property (@(posedge clk) disable iff (rst)
        $past(q_valid) |-> out_hit == $past(hits != '0));
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_hit && out_index == '0 && out_result == '0));
endmodule

// File: tb/tpm_top_tb.sv
module tpm_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 0, rst = 1;
    logic        wr_en = 0, wr_keep = 0, q_valid = 0;
    logic [3:0]  wr_index = 0;
    logic [31:0] wr_value = 0, wr_mask = 0, q_key = 0;
    logic [7:0]  wr_result = 0;
    logic        out_valid, out_hit;
    logic [3:0]  out_index;
    logic [7:0]  out_result;

    int checks = 0, fails = 0;
    logic        m_v [DEPTH];
    logic [31:0] m_val [DEPTH], m_msk [DEPTH];
    logic [7:0]  m_res [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    tpm_top u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pfx(input int len);
        return (len == 0) ? 32'h0 : ~(32'hFFFF_FFFF >> len);
    endfunction

    task automatic wr(input int idx, input logic [31:0] v, input int len, input logic [7:0] r, input logic keep);
        wr_en = 1; wr_index = 4'(idx); wr_value = v; wr_mask = pfx(len); wr_result = r; wr_keep = keep;
        @(posedge clk); #1;
        wr_en = 0;
        m_v[idx] = keep; m_val[idx] = v; m_msk[idx] = pfx(len); m_res[idx] = r;
    endtask

    task automatic model(input logic [31:0] k, output logic h, output logic [3:0] i, output logic [7:0] r);
        h = 0; i = 0; r = 0;
        for (int j = 0; j < DEPTH; j++)
            if (!h && m_v[j] && ((k ^ m_val[j]) & m_msk[j]) == 0) begin
                h = 1; i = 4'(j); r = m_res[j];
            end
    endtask

    task automatic query(input string req, input logic [31:0] k);
        logic h; logic [3:0] i; logic [7:0] r;
        model(k, h, i, r);
        q_valid = 1; q_key = k;
        @(posedge clk); #1;
        q_valid = 0;
        chk(req, {31'b0, out_valid}, 1);
        chk(req, {31'b0, out_hit}, {31'b0, h});
        chk(req, {28'b0, out_index}, {28'b0, i});
        chk(req, {24'b0, out_result}, {24'b0, r});
    endtask

    task automatic t_reset;
        chk("R1", {31'b0, out_valid}, 0);
        chk("R1", {31'b0, out_hit}, 0);
        chk("R1", {24'b0, out_result}, 0);
        query("R1", 32'h1234_5678);
    endtask

    task automatic t_load;
        wr(0, 32'h8009_B000, 24, 8'h24, 1);
        wr(1, 32'h8009_1000, 21, 8'h21, 1);
        wr(2, 32'h8009_0000, 16, 8'h16, 1);
        wr(3, 32'h4100_0000, 8, 8'h08, 1);
        query("R2", 32'h8009_B0FF);
        query("R3", 32'h8009_1777);
        query("R3", 32'h8009_FF00);
        query("R2", 32'h41AB_CDEF);
        query("R5", 32'h0A00_0001);
    endtask

    task automatic t_default;
        wr(15, 32'hDEAD_BEEF, 0, 8'hDF, 1);
        query("R8", 32'h0A00_0001);
        query("R8", 32'h8009_B012);
    endtask

    task automatic t_hold;
        @(posedge clk); #1;
        chk("R4", {31'b0, out_valid}, 0);
        chk("R4", {24'b0, out_result}, {24'b0, 8'h24});
    endtask

    task automatic t_collide;
        logic h; logic [3:0] i; logic [7:0] r;
        model(32'h8009_1234, h, i, r);
        q_valid = 1; q_key = 32'h8009_1234;
        wr_en = 1; wr_index = 4'd0; wr_value = 32'h8009_1234; wr_mask = '1; wr_result = 8'hEE; wr_keep = 1;
        @(posedge clk); #1;
        q_valid = 0; wr_en = 0;
        m_v[0] = 1; m_val[0] = 32'h8009_1234; m_msk[0] = '1; m_res[0] = 8'hEE;
        chk("R7", {24'b0, out_result}, {24'b0, r});
        chk("R7", {28'b0, out_index}, {28'b0, i});
        query("R6", 32'h8009_1234);
        model(32'h8009_1234, h, i, r);
        q_valid = 1; q_key = 32'h8009_1234;
        wr_en = 1; wr_index = 4'd0; wr_keep = 0;
        @(posedge clk); #1;
        q_valid = 0; wr_en = 0; m_v[0] = 0;
        chk("R7", {24'b0, out_result}, {24'b0, 8'hEE});
        query("R6", 32'h8009_1234);
        wr(1, 32'h0, 0, 8'h00, 0);
        query("R6", 32'h8009_1234);
    endtask

    initial begin
        for (int j = 0; j < DEPTH; j++) begin m_v[j] = 0; m_val[j] = 0; m_msk[j] = 0; m_res[j] = 0; end
        repeat (3) @(posedge clk); #1;
        rst = 0;
        t_reset;
        t_load;
        query("R3", 32'h8009_B0FF);
        t_hold;
        t_default;
        t_collide;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule